// File: doc/BRIEF.md
# GPIO Pad Event Detector

This unit controls a single general-purpose I/O pad. Software writes a 32-bit configuration word and reads it back over a plain register port. The word holds the pin function select, separate kill switches for the driver and the receiver, the value to drive, an invert control for the input, a two-bit event selector, and four destination route enables. From that word the unit produces the pad output enable and the output value. It also reports the pad value that software should see.

The pad input first passes a two-flop synchronizer. It is then gated by the receiver disable and optionally inverted. The result feeds an event detector that forwards one registered signal toward an interrupt status block. In level mode that signal tracks the conditioned input. In single-edge mode it pulses for one cycle on a rising conditioned input, which gives falling-edge detection when the invert bit is set. In both-edge mode it pulses on any change. In disabled mode it stays low.

Top module: `gpio_pad_ctl`

## Requirements
- R1: After reset the configuration word reads 0x04000100: function select 0, driver disabled (bit 8 = 1), receiver enabled (bit 9 = 0), event selector = 2 (disabled), and all other bits 0. The pad output enable and the event output are both low.
- R2: The writable bits are bit 0 (drive value), bit 8 (driver disable), bit 9 (receiver disable), bits 13:10 (function select), bits 20:17 (route enables), bit 23 (input invert) and bits 26:25 (event selector). Every other bit reads 0. Bit 1 always shows the sampled input, and a write to bit 1 has no effect.
- R3: The pad output enable is high exactly when the function select is 0 and the driver disable is 0. While it is high, the pad output equals bit 0. While it is low, the pad output is 0.
- R4: A nonzero function select keeps the pad output enable low, whatever the drive bits are.
- R5: The pad value output equals bit 0 when the driver disable is 0. It equals the sampled input bit (bit 1) when the driver disable is 1.
- R6: The sampled input bit follows the pad input two clock edges after the input changes. It reads 0 while the receiver disable is 1.
- R7: With event selector 0 (level), the event output equals the sampled input XOR the invert bit, one clock edge later, for as long as that condition holds.
- R8: With event selector 1 (single edge), the event output pulses high for exactly one cycle. The pulse comes one edge after the sampled input XOR invert goes from 0 to 1. A 1-to-0 change produces no pulse.
- R9: With event selector 3 (both edges), the event output pulses for one cycle on each change of the sampled input XOR invert.
- R10: With event selector 2 (disabled), the event output stays low.
- R11: A write that changes the function select from nonzero to 0 clears all four route enables, whatever the written route bits are. A write that leaves the function select at 0 stores the route bits as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the configuration word |
| cfg_wr_data | input | 32 | Configuration word to write |
| cfg_rd_data | output | 32 | Current configuration word with the sampled input in bit 1 |
| pad_in | input | 1 | Raw, asynchronous pad input |
| pad_oe | output | 1 | Pad driver enable |
| pad_out | output | 1 | Pad driven value |
| gpio_val | output | 1 | Pad value as seen by software |
| evt_o | output | 1 | Event toward the interrupt status block (level or one-cycle pulse) |
| route_en | output | 4 | Route enables toward four event destinations |

## Verification
The hardest situation to reach is a change of the invert bit or the event selector while the detector's stored previous value disagrees with the new conditioned input. That mismatch is what separates the real edge pulses from artefacts of a configuration write. The stimulus reaches it by rewriting the configuration with the pad held at 1 or 0. It then lets the detector settle before it moves the pad again. This proves that the falling-edge mode (inversion plus single edge) ignores the opposite edge, and that level mode follows the inverted sense from the next edge on. Clearing the route enables is reached only by first parking the pad in a native function with all routes set and then writing function select 0.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
  localparam int CFG_W   = 32;
  localparam int MODE_W  = 4;
  localparam int ROUTE_N = 4;

  localparam int B_TXV   = 0;
  localparam int B_RXV   = 1;
  localparam int B_TXDIS = 8;
  localparam int B_RXDIS = 9;
  localparam int B_MODE  = 10;
  localparam int B_ROUTE = 17;
  localparam int B_INV   = 23;
  localparam int B_EV    = 25;

  typedef enum logic [1:0] {
    EV_LEVEL = 2'd0,
    EV_EDGE  = 2'd1,
    EV_OFF   = 2'd2,
    EV_BOTH  = 2'd3
  } evsel_e;

  typedef struct packed {
    evsel_e               ev;
    logic                 inv;
    logic [ROUTE_N-1:0]   route;
    logic [MODE_W-1:0]    mode;
    logic                 rxdis;
    logic                 txdis;
    logic                 txval;
  } pad_cfg_t;

  localparam pad_cfg_t CFG_RST = '{
    ev: EV_OFF, inv: 1'b0, route: '0, mode: '0,
    rxdis: 1'b0, txdis: 1'b1, txval: 1'b0
  };

  function automatic pad_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
    pad_cfg_t c;
    c.ev    = evsel_e'(w[B_EV +: 2]);
    c.inv   = w[B_INV];
    c.route = w[B_ROUTE +: ROUTE_N];
    c.mode  = w[B_MODE +: MODE_W];
    c.rxdis = w[B_RXDIS];
    c.txdis = w[B_TXDIS];
    c.txval = w[B_TXV];
    return c;
  endfunction

  function automatic logic [CFG_W-1:0] wr_mask();
    logic [CFG_W-1:0] m;
    m = '0;
    m[B_EV +: 2]          = '1;
    m[B_INV]              = 1'b1;
    m[B_ROUTE +: ROUTE_N] = '1;
    m[B_MODE +: MODE_W]   = '1;
    m[B_RXDIS]            = 1'b1;
    m[B_TXDIS]            = 1'b1;
    m[B_TXV]              = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic stage_d;
      if (i == 0) begin : g_first
        assign stage_d = d_in;
      end else begin : g_rest
        assign stage_d = stage_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= 1'b0;
        else        stage_q[i] <= stage_d;
      end
    end
  endgenerate

  assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_cfg.sv
module gpio_pad_cfg
  import gpio_pad_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             rx_bit,
  output pad_cfg_t         cfg,
  output logic [CFG_W-1:0] rd_data
);
  localparam logic [CFG_W-1:0] WMASK = wr_mask();

  pad_cfg_t cfg_q, cfg_d;
  logic     cfg_en;
  logic     unused_wr;

  assign unused_wr = ^(wr_data & ~WMASK);

  always_comb begin
    cfg_d  = cfg_q;
    cfg_en = wr_en;
    if (wr_en) begin
      cfg_d = unpack_cfg(wr_data);
      if (cfg_d.mode == '0 && cfg_q.mode != '0) cfg_d.route = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= CFG_RST;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  always_comb begin
    rd_data                   = '0;
    rd_data[B_TXV]            = cfg_q.txval;
    rd_data[B_RXV]            = rx_bit;
    rd_data[B_TXDIS]          = cfg_q.txdis;
    rd_data[B_RXDIS]          = cfg_q.rxdis;
    rd_data[B_MODE +: MODE_W] = cfg_q.mode;
    rd_data[B_ROUTE +: ROUTE_N] = cfg_q.route;
    rd_data[B_INV]            = cfg_q.inv;
    rd_data[B_EV +: 2]        = cfg_q.ev;
  end

  assign cfg = cfg_q;

  assert_route_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[B_MODE +: MODE_W] == '0 && cfg_q.mode != '0) |=> (cfg_q.route == '0));

  assert_rx_readonly_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en) |=> (cfg_q.txval == $past(wr_data[B_TXV])));
endmodule

// File: rtl/gpio_pad_evt.sv
module gpio_pad_evt
  import gpio_pad_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   rx_val,
  input  logic   inv,
  input  evsel_e ev_sel,
  output logic   evt
);
  logic cur;
  logic prev_q, evt_q, evt_d;

  assign cur = rx_val ^ inv;

  always_comb begin
    case (ev_sel)
      EV_LEVEL: evt_d = cur;
      EV_EDGE:  evt_d = cur & ~prev_q;
      EV_BOTH:  evt_d = cur ^ prev_q;
      default:  evt_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      prev_q <= cur;
      evt_q  <= evt_d;
    end
  end

  assign evt = evt_q;

  assert_off_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sel == EV_OFF) |=> !evt_q);

  assert_edge_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sel == EV_EDGE && $past(ev_sel) == EV_EDGE && evt_q) |=> !evt_q);
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl
  import gpio_pad_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [31:0]       cfg_wr_data,
  output logic [31:0]       cfg_rd_data,
  input  logic              pad_in,
  output logic              pad_oe,
  output logic              pad_out,
  output logic              gpio_val,
  output logic              evt_o,
  output logic [3:0]        route_en
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  logic       pad_sync;
  logic       rx_bit;
  pad_cfg_t   cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  gpio_pad_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_in  (pad_in),
    .q_out (pad_sync)
  );

  assign rx_bit = pad_sync & ~cfg.rxdis;

  gpio_pad_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .rx_bit  (rx_bit),
    .cfg     (cfg),
    .rd_data (cfg_rd_data)
  );

  gpio_pad_evt u_evt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .rx_val (rx_bit),
    .inv    (cfg.inv),
    .ev_sel (cfg.ev),
    .evt    (evt_o)
  );

  assign pad_oe   = (cfg.mode == '0) & ~cfg.txdis;
  assign pad_out  = pad_oe & cfg.txval;
  assign gpio_val = cfg.txdis ? rx_bit : cfg.txval;
  assign route_en = cfg.route;

  assert_native_no_drive_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_wr_en && cfg_wr_data[B_MODE +: MODE_W] != '0) |=> !pad_oe);

  assert_out_quiet_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!pad_oe) |-> !pad_out);
endmodule

// File: tb/tb_gpio_pad_ctl.sv
module tb_gpio_pad_ctl;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [31:0] cfg_wr_data;
  logic [31:0] cfg_rd_data;
  logic        pad_in;
  logic        pad_oe, pad_out, gpio_val, evt_o;
  logic [3:0]  route_en;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    string       req;
    int          sel;
    logic [31:0] mask;
    logic [31:0] exp;
  } item_t;
  item_t sbq[$];

  gpio_pad_ctl dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .gpio_val(gpio_val), .evt_o(evt_o), .route_en(route_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  localparam int S_RD = 0, S_OE = 1, S_OUT = 2, S_VAL = 3, S_EVT = 4, S_ROUTE = 5;

  function automatic logic [31:0] mk(int mode, bit txd, bit rxd, bit txv, bit inv, int ev, int route);
    logic [31:0] w;
    w = '0;
    w[13:10] = mode[3:0];
    w[8]     = txd;
    w[9]     = rxd;
    w[0]     = txv;
    w[23]    = inv;
    w[26:25] = ev[1:0];
    w[20:17] = route[3:0];
    return w;
  endfunction

  task automatic expect_item(string req, int sel, logic [31:0] mask, logic [31:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.mask = mask; it.exp = exp;
    sbq.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [31:0] d);
    cfg_wr_en = 1'b1; cfg_wr_data = d;
    tick();
    cfg_wr_en = 1'b0;
  endtask

  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sbq.pop_front();
      case (it.sel)
        S_RD:    act = cfg_rd_data;
        S_OE:    act = {31'b0, pad_oe};
        S_OUT:   act = {31'b0, pad_out};
        S_VAL:   act = {31'b0, gpio_val};
        S_EVT:   act = {31'b0, evt_o};
        default: act = {28'b0, route_en};
      endcase
      n_tests++;
      if ((act & it.mask) !== (it.exp & it.mask)) begin
        n_fail++;
        $display("FAIL %s sel=%0d actual=0x%08h expected=0x%08h", it.req, it.sel,
                 act & it.mask, it.exp & it.mask);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = '0; pad_in = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state
    expect_item("R1", S_RD, 32'hFFFF_FFFF, 32'h0400_0100);
    expect_item("R1", S_OE, 1, 0);
    expect_item("R1", S_EVT, 1, 0);
    tick();

    // R2 writable mask, bit 1 ignored
    wr(32'hFFFF_FFFF);
    expect_item("R2", S_RD, 32'hFFFF_FFFF, 32'h069E_3F01);
    tick();

    // R4 native function never drives
    wr(mk(5, 0, 0, 1, 0, 2, 15));
    expect_item("R4", S_OE, 1, 0);
    expect_item("R4", S_OUT, 1, 0);
    tick();

    // R11 route clear on switch to GPIO
    wr(mk(0, 1, 0, 0, 0, 2, 15));
    expect_item("R11", S_ROUTE, 32'hF, 0);
    expect_item("R11", S_RD, 32'h001E_0000, 0);
    tick();
    wr(mk(0, 1, 0, 0, 0, 2, 15));
    expect_item("R11", S_ROUTE, 32'hF, 32'hF);
    tick();

    // R3 / R5 output path
    wr(mk(0, 0, 0, 1, 0, 2, 0));
    expect_item("R3", S_OE, 1, 1);
    expect_item("R3", S_OUT, 1, 1);
    expect_item("R5", S_VAL, 1, 1);
    tick();
    wr(mk(0, 0, 0, 0, 0, 2, 0));
    expect_item("R3", S_OUT, 1, 0);
    expect_item("R5", S_VAL, 1, 0);
    tick();

    // R6 / R5 input path with sync latency
    wr(mk(0, 1, 0, 1, 0, 2, 0));
    pad_in = 1'b1;
    tick();
    expect_item("R6", S_VAL, 1, 0);
    tick();
    expect_item("R6", S_RD, 32'h2, 32'h2);
    expect_item("R5", S_VAL, 1, 1);
    tick();
    wr(mk(0, 1, 1, 1, 0, 2, 0));
    expect_item("R6", S_RD, 32'h2, 0);
    expect_item("R6", S_VAL, 1, 0);
    tick();

    // R8 rising edge
    pad_in = 1'b0;
    wr(mk(0, 1, 0, 0, 0, 1, 0));
    repeat (4) tick();
    pad_in = 1'b1;
    tick(); tick();
    expect_item("R8", S_EVT, 1, 0);
    tick();
    expect_item("R8", S_EVT, 1, 1);
    tick();
    expect_item("R8", S_EVT, 1, 0);
    tick();

    // R8 falling edge via inversion; opposite edge silent
    wr(mk(0, 1, 0, 0, 1, 1, 0));
    repeat (3) tick();
    pad_in = 1'b0;
    tick(); tick(); tick();
    expect_item("R8", S_EVT, 1, 1);
    tick();
    expect_item("R8", S_EVT, 1, 0);
    pad_in = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      expect_item("R8", S_EVT, 1, 0);
    end

    // R9 both edges
    wr(mk(0, 1, 0, 0, 0, 3, 0));
    repeat (4) tick();
    pad_in = 1'b0;
    tick(); tick(); tick();
    expect_item("R9", S_EVT, 1, 1);
    tick();
    expect_item("R9", S_EVT, 1, 0);
    pad_in = 1'b1;
    tick(); tick(); tick();
    expect_item("R9", S_EVT, 1, 1);
    tick();
    expect_item("R9", S_EVT, 1, 0);

    // R7 level, active high then active low
    wr(mk(0, 1, 0, 0, 0, 0, 0));
    tick();
    expect_item("R7", S_EVT, 1, 1);
    tick();
    expect_item("R7", S_EVT, 1, 1);
    wr(mk(0, 1, 0, 0, 1, 0, 0));
    tick();
    expect_item("R7", S_EVT, 1, 0);
    pad_in = 1'b0;
    tick(); tick(); tick();
    expect_item("R7", S_EVT, 1, 1);
    tick();

    // R10 disabled
    wr(mk(0, 1, 0, 0, 0, 2, 0));
    tick();
    pad_in = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      expect_item("R10", S_EVT, 1, 0);
    end
    pad_in = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick();
      expect_item("R10", S_EVT, 1, 0);
    end

    tick(); tick();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule